// File: doc/BRIEF.md
# Even-Parity Serial Port

A full-duplex asynchronous serial port for a small controller bus. Every frame has one low start bit, eight data bits sent least significant first, an even parity bit right after the last data bit, and one high stop bit. Both directions run from one baud tick generator at sixteen ticks per bit. The bit rate is the clock divided by 16 and by (divisor + 1). A 2 MHz clock with divisor 12 gives about 9615 baud. The same clock with divisor 103 gives about 1202 baud.

Software sets the rate in two steps. It first writes the divisor into a holding register, then writes a separate command address that moves the held value into the live counter. A one-byte transmit buffer accepts the next byte while the previous frame is still shifting out. Received bytes are kept in a read register together with a parity-error flag. Two sticky flags report "frame sent" and "byte received". Software clears either flag by writing 0 to its bit. While the standby input is high the port is frozen in place.

Register map (3-bit address): 0 holds the divisor (write), 1 is the load command (write, data ignored), 2 is the data register (write sends, read returns the last received byte), 3 is status (read), 4 holds the event flags (read, and write 0 to clear).

Top module: `evp_uart`

## Requirements
- R1: After reset, `txd` is 1, both event flags are 0, the live divisor is 0, status reads 8'h02 and address 4 reads 8'h00.
- R2: Writing address 0 changes only the holding register. The bit time changes only after a write to address 1. Each bit then lasts exactly 16*(divisor+1) clock cycles.
- R3: A sent frame is: start 0, data bits 0 to 7, parity equal to the XOR of the data bits, then stop 1. `txd` is 1 when no frame is being sent.
- R4: A write to address 2 queues that byte for sending. A read of address 2 returns the most recently received byte.
- R5: Status bit 1 is 1 when the transmit buffer is empty. It reads 0 right after a data write and returns to 1 once that byte has moved into the shifter. Status bit 0 is 1 when the last received byte failed the even parity check.
- R6: Flag bit 0 (also on `irq_txdone`) is set when a stop bit finishes sending. Flag bit 1 (also on `irq_rxrdy`) is set when a byte is received. Writing address 4 clears each flag whose written bit is 0 and leaves each flag whose written bit is 1. A new event in the same cycle wins over the clear.
- R7: The receiver samples each bit on the 8th of its 16 ticks. If the line is no longer low at the start bit's midpoint, the start is rejected and no byte is delivered.
- R8: A stop bit sampled low is ignored. The byte is still delivered, and no error is raised for it.
- R9: While `standby` is 1, no baud tick occurs. `txd`, the shifters and the flags then hold their values, and the frame resumes after `standby` falls.
- R10: After a frame, the receiver needs the line to be seen high before it accepts a new start. A line held low after a frame therefore yields no extra byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Freezes the port while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq_txdone | output | 1 | Frame-sent event flag |
| irq_rxrdy | output | 1 | Byte-received event flag |

## Verification
A wrong baud counter or a divisor loaded too early shows up within the first frame as a low time on `txd` that differs from 16*(divisor+1) cycles per bit. A wrong transmit shift or parity shows up on `txd` within one frame. It is caught by sampling each bit at its middle and by the looped-back receive register. A wrong receive sample point or a wrong start-rejection rule shows up as a missing, extra or corrupted byte at the data register and `irq_rxrdy`. It appears within one frame of the glitch or break that exposes it. A freeze that leaks during standby appears as a change on `txd` within one bit time.

// File: rtl/evp_uart.sv
module evp_uart #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq_txdone,
  output logic       irq_rxrdy
);
  localparam int OSR        = 16;
  localparam int MID        = OSR / 2 - 1;
  localparam int FRAME_BITS = 11;
  localparam logic [2:0] A_DIVBUF = 3'd0, A_LOAD = 3'd1, A_DATA = 3'd2,
                         A_STAT   = 3'd3, A_FLAG = 3'd4;

  logic [DIV_W-1:0] div_buf, div_act, bcnt;
  logic [7:0]  tx_buf, rx_data;
  logic        tx_full, tx_busy, rx_on, rx_arm, rx_perr, irq_tx, irq_rx;
  logic [10:0] tx_sh;
  logic [8:0]  rx_sh;
  logic [3:0]  tx_tc, tx_bit, rx_tc, rx_bit;
  logic        rx_m, rx_s;

  wire tick    = !standby && (bcnt == div_act);
  wire wr_data = wr_en && addr == A_DATA;
  wire wr_flag = wr_en && addr == A_FLAG;
  wire tx_done = tick && tx_busy && tx_tc == 4'(OSR - 1) && tx_bit == 4'(FRAME_BITS - 1);
  wire rx_mid  = tick && rx_on && rx_tc == 4'(MID);
  wire rx_done = rx_mid && rx_bit == 4'(FRAME_BITS - 1);

  assign txd        = tx_busy ? tx_sh[0] : 1'b1;
  assign irq_txdone = irq_tx;
  assign irq_rxrdy  = irq_rx;

  always_comb begin
    case (addr)
      A_DATA:  rdata = rx_data;
      A_STAT:  rdata = {6'b0, ~tx_full, rx_perr};
      A_FLAG:  rdata = {6'b0, irq_rx, irq_tx};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_buf <= '0;
      div_act <= '0;
      bcnt    <= '0;
    end else begin
      if (wr_en && addr == A_DIVBUF) div_buf <= DIV_W'(wdata);
      if (wr_en && addr == A_LOAD) begin
        div_act <= div_buf;
        bcnt    <= '0;
      end else if (!standby) begin
        bcnt <= tick ? '0 : bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0; tx_full <= 1'b0; tx_busy <= 1'b0;
      tx_sh  <= '1; tx_tc   <= '0;   tx_bit  <= '0;
    end else begin
      if (tick) begin
        if (!tx_busy && tx_full) begin
          tx_busy <= 1'b1;
          tx_sh   <= {1'b1, ^tx_buf, tx_buf, 1'b0};
          tx_tc   <= '0;
          tx_bit  <= '0;
          tx_full <= 1'b0;
        end else if (tx_busy) begin
          tx_tc <= tx_tc + 1'b1;
          if (tx_tc == 4'(OSR - 1)) begin
            tx_sh  <= {1'b1, tx_sh[10:1]};
            tx_bit <= tx_bit + 1'b1;
            if (tx_done) tx_busy <= 1'b0;
          end
        end
      end
      if (wr_data) begin
        tx_buf  <= wdata;
        tx_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1;
      rx_on <= 1'b0; rx_arm <= 1'b0; rx_tc <= '0; rx_bit <= '0;
      rx_sh <= '0; rx_data <= '0; rx_perr <= 1'b0;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      if (tick) begin
        if (!rx_on) begin
          if (rx_s) rx_arm <= 1'b1;
          else if (rx_arm) begin
            rx_on  <= 1'b1;
            rx_arm <= 1'b0;
            rx_tc  <= '0;
            rx_bit <= '0;
          end
        end else begin
          rx_tc <= rx_tc + 1'b1;
          if (rx_mid) begin
            if (rx_bit == 4'd0) begin
              if (rx_s) rx_on <= 1'b0;
              else      rx_bit <= 4'd1;
            end else if (rx_done) begin
              rx_on   <= 1'b0;
              rx_data <= rx_sh[7:0];
              rx_perr <= ^rx_sh;
            end else begin
              rx_sh  <= {rx_s, rx_sh[8:1]};
              rx_bit <= rx_bit + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx <= 1'b0;
      irq_rx <= 1'b0;
    end else begin
      irq_tx <= tx_done | (irq_tx & ~(wr_flag & ~wdata[0]));
      irq_rx <= rx_done | (irq_rx & ~(wr_flag & ~wdata[1]));
    end
  end

  AST_BAUD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= div_act); // R2
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd); // R3
  AST_TX_BUF_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_full)); // R5
  AST_TXDONE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $past(tx_busy) && $past(txd)); // R6
  AST_RXRDY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(rx_on)); // R6
  AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(txd)); // R9
endmodule

// File: tb/evp_uart_bench.sv
module evp_uart_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, standby = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd, rxd, irq_txdone, irq_rxrdy;
  logic       loop = 1'b1, drv = 1'b1;
  assign rxd = loop ? txd : drv;

  int checks = 0, errors = 0;

  // {expected parity, data byte}
  localparam logic [8:0] VEC [8] = '{9'h000, 9'h0FF, 9'h0A5, 9'h101,
                                     9'h180, 9'h107, 9'h113, 9'h096};

  evp_uart u_evp_uart (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd),
    .irq_txdone(irq_txdone), .irq_rxrdy(irq_rxrdy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_txd_low();
    for (int n = 0; n < 4000 && txd !== 1'b0; n++) @(negedge clk);
  endtask

  task automatic wait_flags();
    for (int n = 0; n < 4000 && !(irq_txdone && irq_rxrdy); n++) @(negedge clk);
  endtask

  task automatic low_width(output int w);
    wr(3'd2, 8'h00);
    wait_txd_low();
    w = 0;
    while (txd == 1'b0 && w < 4000) begin @(negedge clk); w++; end
    wait_flags();
    wr(3'd4, 8'h00);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic par, input logic stp);
    logic [10:0] f;
    f = {stp, par, d, 1'b0};
    for (int k = 0; k < 11; k++) begin
      drv = f[k];
      repeat (64) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [10:0] got;
    int          w;
    logic        t, stable;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd idle", {31'd0, txd}, 32'd1);
    check("R1 flags low", {30'd0, irq_rxrdy, irq_txdone}, 32'd0);
    rd(3'd3, r); check("R1 status", {24'd0, r}, 32'h02);
    rd(3'd4, r); check("R1 flag reg", {24'd0, r}, 32'h00);

    low_width(w); check("R2 bit time div 0", w, 32'd160);
    wr(3'd0, 8'd3);
    low_width(w); check("R2 buffer alone no effect", w, 32'd160);
    wr(3'd1, 8'h00);
    low_width(w); check("R2 bit time div 3", w, 32'd640);

    for (int i = 0; i < 8; i++) begin
      wr(3'd2, VEC[i][7:0]);
      wait_txd_low();
      repeat (32) @(negedge clk);
      got[0] = txd;
      for (int k = 1; k < 11; k++) begin
        repeat (64) @(negedge clk);
        got[k] = txd;
      end
      check("R3 frame bits", {21'd0, got}, {21'd0, 1'b1, VEC[i][8], VEC[i][7:0], 1'b0});
      wait_flags();
      rd(3'd2, r); check("R4 received byte", {24'd0, r}, {24'd0, VEC[i][7:0]});
      rd(3'd3, r); check("R5 no parity error", {31'd0, r[0]}, 32'd0);
      rd(3'd4, r); check("R6 both flags", {24'd0, r}, 32'h03);
      wr(3'd4, 8'h00);
    end

    wr(3'd2, 8'h11);
    rd(3'd3, r); check("R5 buffer full after write", {31'd0, r[1]}, 32'd0);
    wait_txd_low();
    @(negedge clk);
    rd(3'd3, r); check("R5 buffer empty after start", {31'd0, r[1]}, 32'd1);
    wait_flags();
    wr(3'd4, 8'h02);
    check("R6 selective clear", {30'd0, irq_rxrdy, irq_txdone}, 32'b10);
    wr(3'd4, 8'h01);
    check("R6 clear rx flag", {30'd0, irq_rxrdy, irq_txdone}, 32'b00);

    loop = 1'b0; drv = 1'b1;
    repeat (20) @(negedge clk);
    send_frame(8'h5A, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    check("R6 rx flag on bad parity", {31'd0, irq_rxrdy}, 32'd1);
    rd(3'd2, r); check("R4 byte with bad parity", {24'd0, r}, 32'h5A);
    rd(3'd3, r); check("R5 parity error set", {31'd0, r[0]}, 32'd1);
    wr(3'd4, 8'h00);
    send_frame(8'h5A, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    rd(3'd3, r); check("R5 parity error cleared", {31'd0, r[0]}, 32'd0);
    wr(3'd4, 8'h00);

    send_frame(8'hC3, 1'b0, 1'b0);
    repeat (200) @(negedge clk);
    check("R8 byte delivered with low stop", {31'd0, irq_rxrdy}, 32'd1);
    rd(3'd2, r); check("R8 data", {24'd0, r}, 32'hC3);
    rd(3'd3, r); check("R8 no error flagged", {31'd0, r[0]}, 32'd0);
    wr(3'd4, 8'h00);
    drv = 1'b1;
    repeat (800) @(negedge clk);
    check("R10 no byte from held-low line", {31'd0, irq_rxrdy}, 32'd0);

    drv = 1'b0;
    repeat (16) @(negedge clk);
    drv = 1'b1;
    repeat (800) @(negedge clk);
    check("R7 short start rejected", {31'd0, irq_rxrdy}, 32'd0);
    rd(3'd2, r); check("R7 data untouched", {24'd0, r}, 32'hC3);

    loop = 1'b1;
    wr(3'd2, 8'h00);
    wait_txd_low();
    repeat (100) @(negedge clk);
    standby = 1'b1;
    t = txd; stable = 1'b1;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (txd !== t) stable = 1'b0;
    end
    check("R9 txd frozen", {31'd0, stable}, 32'd1);
    check("R9 no flag in standby", {30'd0, irq_rxrdy, irq_txdone}, 32'd0);
    standby = 1'b0;
    wait_flags();
    check("R9 frame resumes", {30'd0, irq_rxrdy, irq_txdone}, 32'b11);
    rd(3'd2, r); check("R9 byte after resume", {24'd0, r}, 32'h00);
    rd(3'd3, r); check("R9 parity ok", {31'd0, r[0]}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule